// File: doc/BRIEF.md
# Aliased Sub-Register File

This block holds eight 32-bit general-purpose registers. Each register can be reached through more than one view of the same storage. Any register can be read or written as a full word or as its low 16-bit half. The first four registers also offer two byte views: one over bits 7:0 and one over bits 15:8. A narrow write changes only the bits that the view covers. A narrow read places the selected field at bit 0 of the 32-bit read bus and fills the upper bits with zeros.

The block has one write port and two independent read ports. Each port carries a register index and a two-bit view code. Reads are combinational and return the stored value as it stands before the next clock edge. Writes take effect at the clock edge.

A byte view on registers 4 to 7 does not exist. Such an access raises the error output of that port for the same cycle. An illegal write changes nothing, and an illegal read returns zero.

Top module: `gpr_alias_file`

## Requirements
- R1: With view code 2'b00 (word), a write stores all 32 bits of `wr_data`, and a read returns all 32 bits of the selected register.
- R2: With view code 2'b01 (half), a write replaces bits 15:0 and keeps bits 31:16. A read returns bits 15:0 with zeros in bits 31:16.
- R3: With view code 2'b10 (low byte) on registers 0 to 3, a write replaces bits 7:0 and keeps the rest. A read returns bits 7:0 with zeros in bits 31:8.
- R4: With view code 2'b11 (high byte) on registers 0 to 3, a write replaces bits 15:8 from `wr_data[7:0]` and keeps the rest. A read returns the old bits 15:8 on bus bits 7:0, with zeros in bits 31:8.
- R5: A byte view code (2'b10 or 2'b11) on registers 4 to 7 is illegal. `wr_err` is high in that cycle when `wr_en` is high, and `rdN_err` is high in that cycle. An illegal write leaves every register unchanged, and an illegal read returns zero.
- R6: A read of the register being written in the same cycle returns the value held before the write. The new value is visible after the clock edge.
- R7: A synchronous reset (`rst` high at a rising edge) clears all eight registers to zero.
- R8: The two read ports act independently. Each port returns its own index and view in the same cycle.
- R9: With `wr_en` low, no register changes and `wr_err` stays low, whatever the write index, view and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_view | input | 2 | Write view code |
| wr_data | input | 32 | Write data, with the field right-aligned |
| wr_err | output | 1 | Illegal write view in this cycle |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_view | input | 2 | Read port 0 view code |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd0_err | output | 1 | Read port 0 illegal view |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_view | input | 2 | Read port 1 view code |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| rd1_err | output | 1 | Read port 1 illegal view |

## Verification
The hardest state to reach from the ports is a register whose content was built by a chain of overlapping partial writes. Such a chain can hide a merge that clobbers bits outside its field.

The stimulus reaches that state by sweeping every register through all four view codes in turn, with several distinct data patterns. Each register therefore accumulates word, half and byte writes on top of one another. The bench also reads back both the same view and the full word on the second port.

Each write cycle also reads the target register on port 0, which exposes the old-value rule in the same cycle. A later cycle with the write disabled, carrying an illegal index and view, confirms that nothing moved.

// File: rtl/gpr_alias_pkg.sv
`timescale 1ns/1ps
package gpr_alias_pkg;

    typedef enum logic [1:0] {
        VIEW_WORD = 2'b00,
        VIEW_HALF = 2'b01,
        VIEW_LOB  = 2'b10,
        VIEW_HIB  = 2'b11
    } view_e;

    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned HALF_BITS = 16;

endpackage

// File: rtl/gpr_view_decode.sv
`timescale 1ns/1ps
// Turns an index and a view code into a field mask, the field's low bit and a legality flag.
module gpr_view_decode
    import gpr_alias_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned BYTE_REGS = 4,
    localparam int unsigned SH_W     = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  idx,
    input  view_e             view,
    output logic              legal,
    output logic [DATA_W-1:0] field_mask,
    output logic [SH_W-1:0]   field_lsb
);

    localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-HALF_BITS){1'b0}}, {HALF_BITS{1'b1}}};
    localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_BITS){1'b0}}, {BYTE_BITS{1'b1}}};

    logic byte_ok;
    assign byte_ok = ({1'b0, idx} < (IDX_W+1)'(BYTE_REGS));

    always_comb begin
        legal      = 1'b1;
        field_mask = '1;
        field_lsb  = '0;
        unique case (view)
            VIEW_WORD: begin
                field_mask = '1;
            end
            VIEW_HALF: begin
                field_mask = HALF_MASK;
            end
            VIEW_LOB: begin
                legal      = byte_ok;
                field_mask = byte_ok ? BYTE_MASK : '0;
            end
            VIEW_HIB: begin
                legal      = byte_ok;
                field_mask = byte_ok ? (BYTE_MASK << BYTE_BITS) : '0;
                field_lsb  = SH_W'(BYTE_BITS);
            end
            default: begin
                legal      = 1'b0;
                field_mask = '0;
            end
        endcase
    end

endmodule

// File: rtl/gpr_write_merge.sv
`timescale 1ns/1ps
// Places right-aligned write data into its field and keeps the other bits.
module gpr_write_merge #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [DATA_W-1:0] field_mask,
    input  logic [SH_W-1:0]   field_lsb,
    output logic [DATA_W-1:0] new_val
);

    logic [DATA_W-1:0] placed;

    always_comb begin
        placed  = (wr_val << field_lsb) & field_mask;
        new_val = (old_val & ~field_mask) | placed;
    end

endmodule

// File: rtl/gpr_read_extract.sv
`timescale 1ns/1ps
// Pulls a field out of a register and right-aligns it with zero fill.
module gpr_read_extract #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] field_mask,
    input  logic [SH_W-1:0]   field_lsb,
    output logic [DATA_W-1:0] rd_val
);

    always_comb begin
        rd_val = (reg_val & field_mask) >> field_lsb;
    end

endmodule

// File: rtl/gpr_alias_file.sv
`timescale 1ns/1ps
module gpr_alias_file
    import gpr_alias_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BYTE_REGS = 4,
    localparam int unsigned IDX_W    = $clog2(NUM_REGS),
    localparam int unsigned SH_W     = $clog2(DATA_W),
    localparam int unsigned NUM_RD   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_view,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [1:0]        rd0_view,
    output logic [DATA_W-1:0] rd0_data,
    output logic              rd0_err,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic [1:0]        rd1_view,
    output logic [DATA_W-1:0] rd1_data,
    output logic              rd1_err
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } state_t;

    state_t st_d, st_q;

    // ---------------- write path ----------------
    logic              wr_legal;
    logic [DATA_W-1:0] wr_mask;
    logic [SH_W-1:0]   wr_lsb;
    logic [DATA_W-1:0] wr_merged;

    gpr_view_decode #(
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .BYTE_REGS(BYTE_REGS)
    ) i_wr_dec (
        .idx       (wr_idx),
        .view      (view_e'(wr_view)),
        .legal     (wr_legal),
        .field_mask(wr_mask),
        .field_lsb (wr_lsb)
    );

    gpr_write_merge #(
        .DATA_W(DATA_W)
    ) i_wr_merge (
        .old_val   (st_q.regs[wr_idx]),
        .wr_val    (wr_data),
        .field_mask(wr_mask),
        .field_lsb (wr_lsb),
        .new_val   (wr_merged)
    );

    assign wr_err = wr_en && !wr_legal;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (wr_en && wr_legal) begin
            st_d.regs[wr_idx] = wr_merged;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // ---------------- read paths ----------------
    logic [NUM_RD-1:0][IDX_W-1:0]  rp_idx;
    logic [NUM_RD-1:0][1:0]        rp_view;
    logic [NUM_RD-1:0][DATA_W-1:0] rp_data;
    logic [NUM_RD-1:0]             rp_legal;

    assign rp_idx  = {rd1_idx, rd0_idx};
    assign rp_view = {rd1_view, rd0_view};

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        logic [DATA_W-1:0] mask;
        logic [SH_W-1:0]   lsb;

        gpr_view_decode #(
            .DATA_W   (DATA_W),
            .IDX_W    (IDX_W),
            .BYTE_REGS(BYTE_REGS)
        ) i_rd_dec (
            .idx       (rp_idx[g]),
            .view      (view_e'(rp_view[g])),
            .legal     (rp_legal[g]),
            .field_mask(mask),
            .field_lsb (lsb)
        );

        gpr_read_extract #(
            .DATA_W(DATA_W)
        ) i_rd_ext (
            .reg_val   (st_q.regs[rp_idx[g]]),
            .field_mask(mask),
            .field_lsb (lsb),
            .rd_val    (rp_data[g])
        );

        // R2 R3 R4: narrow views never drive the upper half of the bus
        a_r4_narrow_zero_ext: assert property (@(posedge clk) disable iff (rst)
            (rp_view[g] != 2'b00) |-> (rp_data[g][DATA_W-1:HALF_BITS] == '0));

        // R5: an illegal read returns zero
        a_r5_illegal_read_zero: assert property (@(posedge clk) disable iff (rst)
            !rp_legal[g] |-> (rp_data[g] == '0));
    end

    assign rd0_data = rp_data[0];
    assign rd1_data = rp_data[1];
    assign rd0_err  = !rp_legal[0];
    assign rd1_err  = !rp_legal[1];

    // ---------------- assertions ----------------
    a_r1_word_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == 2'b00) |=> (st_q.regs[$past(wr_idx)] == $past(wr_data)));

    a_r2_half_write_keeps_top: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == 2'b01) |=>
        (st_q.regs[$past(wr_idx)][DATA_W-1:HALF_BITS] == $past(st_q.regs[wr_idx][DATA_W-1:HALF_BITS])));

    a_r5_illegal_write_holds: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> (st_q.regs == $past(st_q.regs)));

    a_r5_err_needs_byte_high_reg: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> (wr_en && wr_view[1] && (int'(wr_idx) >= BYTE_REGS)));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (st_q.regs == $past(st_q.regs)));

    a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_q.regs == '0));

endmodule

// File: tb/test_gpr_alias_file.sv
`timescale 1ns/1ps
module test_gpr_alias_file;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [1:0]  wr_view;
    logic [31:0] wr_data;
    logic        wr_err;
    logic [2:0]  rd0_idx, rd1_idx;
    logic [1:0]  rd0_view, rd1_view;
    logic [31:0] rd0_data, rd1_data;
    logic        rd0_err, rd1_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] model [8];

    always #2 clk = ~clk;

    gpr_alias_file i_gpr_alias_file (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data), .wr_err(wr_err),
        .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_data(rd1_data), .rd1_err(rd1_err)
    );

    function automatic bit legal(int idx, int v);
        return (v < 2) || (idx < 4);
    endfunction

    function automatic logic [31:0] ext(logic [31:0] r, int idx, int v);
        if (!legal(idx, v)) return 32'h0;
        case (v)
            0:       return r;
            1:       return {16'h0, r[15:0]};
            2:       return {24'h0, r[7:0]};
            default: return {24'h0, r[15:8]};
        endcase
    endfunction

    function automatic logic [31:0] merge(logic [31:0] o, int v, logic [31:0] d);
        case (v)
            0:       return d;
            1:       return {o[31:16], d[15:0]};
            2:       return {o[31:8], d[7:0]};
            default: return {o[31:16], d[7:0], o[7:0]};
        endcase
    endfunction

    function automatic string tag(int idx, int v);
        if (!legal(idx, v)) return "R5";
        case (v)
            0:       return "R1";
            1:       return "R2";
            2:       return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the combinational reads, then let the edge commit.
    task automatic op(bit wen, int widx, int wv, logic [31:0] wd,
                      int r0, int r0v, int r1, int r1v, string tag0);
        string t0;
        @(negedge clk);
        wr_en = wen; wr_idx = 3'(widx); wr_view = 2'(wv); wr_data = wd;
        rd0_idx = 3'(r0); rd0_view = 2'(r0v); rd1_idx = 3'(r1); rd1_view = 2'(r1v);
        #1;
        t0 = (tag0 != "") ? tag0 : ((wen && r0 == widx) ? "R6" : tag(r0, r0v));
        chk(t0, rd0_data, ext(model[r0], r0, r0v));
        chk("R5", 32'(rd0_err), 32'(!legal(r0, r0v)));
        chk("R8", rd1_data, ext(model[r1], r1, r1v));
        chk("R5", 32'(rd1_err), 32'(!legal(r1, r1v)));
        chk(wen ? "R5" : "R9", 32'(wr_err), 32'(wen && !legal(widx, wv)));
        @(posedge clk);
        if (wen && legal(widx, wv)) model[widx] = merge(model[widx], wv, wd);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 32'h0;
    endtask

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'hA5C3_1E96; pats[1] = 32'h5A3C_E169;
        pats[2] = 32'hFFFF_FFFF; pats[3] = 32'h0123_4567;
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_view = '0; wr_data = '0;
        rd0_idx = '0; rd0_view = '0; rd1_idx = '0; rd1_view = '0;
        repeat (3) @(posedge clk);
        do_reset();

        // R7: every register reads zero after reset
        for (int i = 0; i < 8; i++) op(1'b0, 0, 0, 32'h0, i, 0, i, 1, "R7");

        // Sweep: every register, every view, several patterns
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 8; i++) begin
                for (int v = 0; v < 4; v++) begin
                    logic [31:0] d;
                    d = pats[p] ^ (32'(i) * 32'h1111_1111) ^ (32'(v) << 5);
                    op(1'b1, i, v, d, i, v, (i + 1) % 8, 0, "");
                    op(1'b0, 7, 3, ~d, i, 0, i, v, "");
                    op(1'b0, i, 0, 32'hDEAD_BEEF, i, 0, (i + 4) % 8, v, "R9");
                end
            end
        end

        // R7: reset in the middle of operation clears all contents
        do_reset();
        for (int i = 0; i < 8; i++) op(1'b0, 0, 0, 32'h0, i, 0, 7 - i, 0, "R7");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule